// File: doc/BRIEF.md
# Sine-Triangle Unipolar PWM Modulator

This block produces the four gate-drive bits for a full H-bridge. One triangle carrier and one sine reference come from two 32-bit phase accumulators that run from the same clock. The output frequency of each accumulator is `tuning_word * f_clk / 2^32`. The sine is scaled by an amplitude input. The sine and its negation are each compared against the same triangle, and the two results drive the two bridge legs. This gives three-level unipolar switching.

Each leg leaves the block as a complementary pair. A one-cycle strobe marks the start of every sine period so that an observer can line up on it. Dead time, filtering and the power stage lie outside the block.

The sine comes from a quarter-wave table that is computed when the design is elaborated, and symmetry folding covers the rest of the period. At a 200 MHz clock, tuning words near 2^23 and 2^24 give carriers of 400 kHz and 800 kHz. Words between about 429,500 and 2,147,500 cover sine frequencies of 20 kHz to 100 kHz.

Top module: `sine_tri_pwm`

## Requirements
- R1: While reset is held, and after it is released with `en_i` low, `gate_o` is 4'b0000 and `sync_o` is 0.
- R2: One clock edge after `en_i` is sampled low, `gate_o` is 4'b0000 and stays 0. While `en_i` is low both accumulators hold their phase, so `sync_o` does not pulse.
- R3: While enabled, `gate_o[0]` is the leg-A switch bit and `gate_o[1]` is its complement. `gate_o[2]` is the leg-B switch bit and `gate_o[3]` is its complement.
- R4: The carrier period is 2^32 / `car_tw_i` clocks. With zero amplitude, a word of 2^26 gives leg-A high runs of 32 clocks and low runs of 32 clocks. A word of 2^27 gives high runs of 16 clocks.
- R5: `sync_o` is high for exactly one clock each time the sine accumulator wraps, so it pulses every 2^32 / `sin_tw_i` clocks.
- R6: With `amp_i` = 0, leg A and leg B are identical and each is high for exactly half of every carrier period.
- R7: The `gate_o` sample in which `sync_o` is high starts the positive sine half. Over that half (2^31 / `sin_tw_i` samples) leg B is never high while leg A is low. Over the following negative half, leg A is never high while leg B is low.
- R8: Leg A's duty over the positive half grows with `amp_i` (full scale 65535), roughly as 0.5 + 0.318 * `amp_i`/65536. Leg B behaves the same way over the negative half. The scaled reference never exceeds the carrier's signed range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low forces gates off and freezes phases |
| car_tw_i | input | 32 | Carrier tuning word |
| sin_tw_i | input | 32 | Sine tuning word |
| amp_i | input | 16 | Modulation amplitude, unsigned, 65535 is full scale |
| gate_o | output | 4 | {legB_n, legB, legA_n, legA} |
| sync_o | output | 1 | One-clock strobe at the start of each sine period |

## Verification
The datapath has four register stages: phase, waveform, scaled reference and gate. The strobe travels through the same four stages, so the gate sample that appears together with `sync_o` belongs to sine phase zero. The half-period windows of R7 and R8 are therefore counted from the sample where the strobe is seen, with no guessed offset. Lowering `en_i` takes effect at the next edge, so the gate check is sampled at the falling edge that follows. Every sample is taken at a falling clock edge, and after each change of tuning word or amplitude the bench waits at least eight clocks before it counts.

// File: rtl/sinetri_pkg.sv
package sinetri_pkg;

    localparam int ACC_W     = 32;
    localparam int CAR_W     = 16;
    localparam int AMP_W     = 16;
    localparam int TBL_ADDR_W = 8;
    localparam int MAG_W     = CAR_W - 1;
    localparam int TBL_DEPTH = 1 << TBL_ADDR_W;
    localparam int SPH_W     = TBL_ADDR_W + 2;
    localparam int PROD_W    = CAR_W + AMP_W + 1;

    typedef logic signed [CAR_W-1:0] sample_t;

    // bit 0 = leg A, bit 1 = leg A complement, bit 2 = leg B, bit 3 = complement
    typedef struct packed {
        logic leg_b_n;
        logic leg_b;
        logic leg_a_n;
        logic leg_a;
    } gate_t;

    typedef struct packed {
        logic    wrap;
        sample_t tri_s;
        sample_t sine_s;
    } wave_t;

    // Rational sine approximation over a half period, sampled at mid-points
    function automatic int quarter_sine(int idx, int depth, int mag_w);
        longint y, h, num, den, full;
        y    = 2 * longint'(idx) + 1;
        h    = 4 * longint'(depth);
        full = (longint'(1) << mag_w) - 1;
        num  = 16 * y * (h - y) * full;
        den  = 5 * h * h - 4 * y * (h - y);
        return int'(num / den);
    endfunction

    // Fold the carrier phase into a signed triangle sample
    function automatic sample_t fold_triangle(logic [CAR_W:0] ph);
        logic [CAR_W-1:0] f;
        f = ph[CAR_W] ? ~ph[CAR_W-1:0] : ph[CAR_W-1:0];
        return sample_t'({~f[CAR_W-1], f[CAR_W-2:0]});
    endfunction

endpackage

// File: rtl/st_phase_acc.sv
module st_phase_acc #(
    parameter int ACC_W = sinetri_pkg::ACC_W,
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] tw,
    output logic [OUT_W-1:0] phase_o,
    output logic             wrap_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, tw};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            wrap_o <= 1'b0;
        end else begin
            wrap_o <= en & sum[ACC_W];
            if (en) acc_q <= sum[ACC_W-1:0];
        end
    end

    assign phase_o = acc_q[ACC_W-1 -: OUT_W];

    p_hold_phase_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc_q));

    p_wrap_small_r5: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> (acc_q < $past(tw)));

endmodule

// File: rtl/st_wave_gen.sv
module st_wave_gen
    import sinetri_pkg::*;
#(
    parameter int ADDR_W = TBL_ADDR_W,
    parameter int CW     = CAR_W,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int MW    = CW - 1,
    localparam int SW    = ADDR_W + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sin_ph_i,
    input  logic [CW:0]   car_ph_i,
    input  logic          wrap_i,
    output wave_t         wave_o
);
    logic [MW-1:0]     rom [DEPTH];
    logic [ADDR_W-1:0] addr;
    logic [MW-1:0]     mag;
    sample_t           sine_n;

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = MW'(quarter_sine(g, DEPTH, MW));
    end

    // quadrant bit mirrors the address, half bit flips the sign
    assign addr   = sin_ph_i[SW-2] ? ~sin_ph_i[ADDR_W-1:0] : sin_ph_i[ADDR_W-1:0];
    assign mag    = rom[addr];
    assign sine_n = sin_ph_i[SW-1] ? -sample_t'({1'b0, mag}) : sample_t'({1'b0, mag});

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_o <= '0;
        end else begin
            wave_o.sine_s <= sine_n;
            wave_o.tri_s  <= fold_triangle(car_ph_i);
            wave_o.wrap   <= wrap_i;
        end
    end

    p_sine_sign_r7: assert property (@(posedge clk) disable iff (rst)
        !sin_ph_i[SW-1] |=> !wave_o.sine_s[CW-1]);

endmodule

// File: rtl/st_leg_cmp.sv
module st_leg_cmp
    import sinetri_pkg::*;
#(
    parameter int CW = CAR_W,
    parameter int AW = AMP_W,
    localparam int PW = CW + AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  wave_t         wave_i,
    input  logic [AW-1:0] amp_i,
    output gate_t         gate_o,
    output logic          sync_o
);
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] ref_full;
    sample_t              ref_q;
    sample_t              tri_q;
    logic                 wrap_q;
    logic                 leg_a;
    logic                 leg_b;

    assign prod     = PW'(wave_i.sine_s) * $signed({1'b0, amp_i});
    assign ref_full = prod >>> AW;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            tri_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            ref_q  <= ref_full[CW-1:0];
            tri_q  <= wave_i.tri_s;
            wrap_q <= wave_i.wrap;
        end
    end

    assign leg_a = ref_q > tri_q;
    assign leg_b = (-ref_q) > tri_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_o <= '0;
            sync_o <= 1'b0;
        end else begin
            sync_o <= en & wrap_q;
            if (en) begin
                gate_o.leg_a   <= leg_a;
                gate_o.leg_a_n <= ~leg_a;
                gate_o.leg_b   <= leg_b;
                gate_o.leg_b_n <= ~leg_b;
            end else begin
                gate_o <= '0;
            end
        end
    end

    p_ref_range_r8: assert property (@(posedge clk) disable iff (rst)
        (ref_full[PW-1:CW-1] == '0) || (ref_full[PW-1:CW-1] == '1));

    p_zero_amp_r6: assert property (@(posedge clk) disable iff (rst)
        (amp_i == '0) |=> (ref_q == '0));

    p_unipolar_pos_r7: assert property (@(posedge clk) disable iff (rst)
        !ref_q[CW-1] |=> !(gate_o.leg_b && !gate_o.leg_a));

    p_unipolar_neg_r7: assert property (@(posedge clk) disable iff (rst)
        ref_q[CW-1] |=> !(gate_o.leg_a && !gate_o.leg_b));

endmodule

// File: rtl/sine_tri_pwm.sv
module sine_tri_pwm
    import sinetri_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [ACC_W-1:0]  car_tw_i,
    input  logic [ACC_W-1:0]  sin_tw_i,
    input  logic [AMP_W-1:0]  amp_i,
    output logic [3:0]        gate_o,
    output logic              sync_o
);
    logic [SPH_W-1:0] sin_ph;
    logic [CAR_W:0]   car_ph;
    logic             sin_wrap;
    logic             car_wrap_unused;
    wave_t            wave;
    gate_t            gate;

    st_phase_acc #(.ACC_W(ACC_W), .OUT_W(SPH_W)) u_sin_acc (
        .clk(clk), .rst(rst), .en(en_i), .tw(sin_tw_i),
        .phase_o(sin_ph), .wrap_o(sin_wrap)
    );

    st_phase_acc #(.ACC_W(ACC_W), .OUT_W(CAR_W + 1)) u_car_acc (
        .clk(clk), .rst(rst), .en(en_i), .tw(car_tw_i),
        .phase_o(car_ph), .wrap_o(car_wrap_unused)
    );

    st_wave_gen #(.ADDR_W(TBL_ADDR_W), .CW(CAR_W)) u_wave (
        .clk(clk), .rst(rst), .sin_ph_i(sin_ph), .car_ph_i(car_ph),
        .wrap_i(sin_wrap), .wave_o(wave)
    );

    st_leg_cmp #(.CW(CAR_W), .AW(AMP_W)) u_cmp (
        .clk(clk), .rst(rst), .en(en_i), .wave_i(wave), .amp_i(amp_i),
        .gate_o(gate), .sync_o(sync_o)
    );

    assign gate_o = gate;

    p_carrier_wrap_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        car_wrap_unused |-> $past(en_i));

endmodule

// File: tb/tb_sine_tri_pwm.sv
module tb_sine_tri_pwm;

    logic        clk = 1'b0;
    logic        rst;
    logic        en_i;
    logic [31:0] car_tw_i;
    logic [31:0] sin_tw_i;
    logic [15:0] amp_i;
    logic [3:0]  gate_o;
    logic        sync_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    sine_tri_pwm dut (
        .clk(clk), .rst(rst), .en_i(en_i), .car_tw_i(car_tw_i),
        .sin_tw_i(sin_tw_i), .amp_i(amp_i), .gate_o(gate_o), .sync_o(sync_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_sync();
        int guard = 0;
        @(negedge clk);
        while (!sync_o && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // leg A run lengths: returns high then low length
    task automatic leg_runs(output int hi_len, output int lo_len);
        int guard = 0;
        @(negedge clk);
        while (gate_o[0] && guard < 1000) begin @(negedge clk); guard++; end
        while (!gate_o[0] && guard < 2000) begin @(negedge clk); guard++; end
        hi_len = 0;
        while (gate_o[0] && hi_len < 1000) begin hi_len++; @(negedge clk); end
        lo_len = 0;
        while (!gate_o[0] && lo_len < 1000) begin lo_len++; @(negedge clk); end
    endtask

    task automatic t_reset();
        rst = 1'b1; en_i = 1'b0; car_tw_i = 32'h0400_0000;
        sin_tw_i = 32'h0040_0000; amp_i = '0;
        tick(4);
        chk(gate_o == 4'b0 && sync_o == 1'b0, "R1 in reset", gate_o, 0);
        rst = 1'b0;
        tick(3);
        chk(gate_o == 4'b0 && sync_o == 1'b0, "R1 after reset", gate_o, 0);
    endtask

    task automatic t_amp_zero();
        int hi, lo, mism, comp, hi_cnt;
        car_tw_i = 32'h0400_0000; amp_i = '0; en_i = 1'b1;
        tick(8);
        mism = 0; comp = 0; hi_cnt = 0;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            if (gate_o[0] != gate_o[2]) mism++;
            if (gate_o[1] != ~gate_o[0] || gate_o[3] != ~gate_o[2]) comp++;
            if (gate_o[0]) hi_cnt++;
        end
        chk(mism == 0, "R6 legs identical", mism, 0);
        chk(hi_cnt == 64, "R6 half duty", hi_cnt, 64);
        chk(comp == 0, "R3 complements at zero amplitude", comp, 0);
        leg_runs(hi, lo);
        chk(hi == 32, "R4 high run at 2^26", hi, 32);
        chk(lo == 32, "R4 low run at 2^26", lo, 32);
    endtask

    task automatic t_sync();
        int gap;
        wait_sync();
        chk(sync_o == 1'b1, "R5 strobe seen", sync_o, 1);
        @(negedge clk);
        chk(sync_o == 1'b0, "R5 strobe one clock wide", sync_o, 0);
        gap = 1;
        while (!sync_o && gap < 3000) begin @(negedge clk); gap++; end
        chk(gap == 1024, "R5 strobe spacing", gap, 1024);
    endtask

    task automatic t_unipolar(input logic [15:0] amp, input int lo_lim, input int hi_lim, input string tag);
        int bad_pos, bad_neg, pa, nb, comp;
        amp_i = amp;
        tick(8);
        wait_sync();
        bad_pos = 0; bad_neg = 0; pa = 0; nb = 0; comp = 0;
        for (int i = 0; i < 512; i++) begin
            if (gate_o[2] && !gate_o[0]) bad_pos++;
            if (gate_o[0]) pa++;
            if (gate_o[1] != ~gate_o[0] || gate_o[3] != ~gate_o[2]) comp++;
            @(negedge clk);
        end
        for (int i = 0; i < 512; i++) begin
            if (gate_o[0] && !gate_o[2]) bad_neg++;
            if (gate_o[2]) nb++;
            if (gate_o[1] != ~gate_o[0] || gate_o[3] != ~gate_o[2]) comp++;
            @(negedge clk);
        end
        chk(bad_pos == 0, {"R7 positive half ", tag}, bad_pos, 0);
        chk(bad_neg == 0, {"R7 negative half ", tag}, bad_neg, 0);
        chk(pa >= lo_lim && pa <= hi_lim, {"R8 leg A duty ", tag}, pa, (lo_lim + hi_lim) / 2);
        chk(nb >= lo_lim && nb <= hi_lim, {"R8 leg B duty ", tag}, nb, (lo_lim + hi_lim) / 2);
        chk(comp == 0, {"R3 complements ", tag}, comp, 0);
    endtask

    task automatic t_disable();
        int on_cnt, syn_cnt;
        en_i = 1'b0;
        @(negedge clk);
        chk(gate_o == 4'b0, "R2 gates off one edge later", gate_o, 0);
        on_cnt = 0; syn_cnt = 0;
        for (int i = 0; i < 2100; i++) begin
            @(negedge clk);
            if (gate_o != 4'b0) on_cnt++;
            if (sync_o) syn_cnt++;
        end
        chk(on_cnt == 0, "R2 gates stay off", on_cnt, 0);
        chk(syn_cnt == 0, "R2 no strobe while frozen", syn_cnt, 0);
        en_i = 1'b1;
    endtask

    task automatic t_carrier_change();
        int hi, lo;
        car_tw_i = 32'h0800_0000; amp_i = '0;
        tick(8);
        leg_runs(hi, lo);
        chk(hi == 16, "R4 high run at 2^27", hi, 16);
        chk(lo == 16, "R4 low run at 2^27", lo, 16);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_amp_zero();
        t_sync();
        t_unipolar(16'hFFFF, 380, 460, "full");
        t_unipolar(16'h8000, 300, 375, "half");
        t_disable();
        t_sync();
        t_carrier_change();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule